// File: doc/BRIEF.md
# Bypassable Pixel Clock Divider

This block turns a reference clock into the timing base for a display panel's pixel stream. It keeps one 32-bit configuration word, written over a simple single-cycle write port. From that word it takes a division code, a bypass flag and an edge-select flag. The division code is split into two fields that are not next to each other in the word. The block produces two outputs. The first is a one-cycle clock enable, `pix_ce`, that marks the reference cycle in which pixel data should be launched. The second is a divided clock level, `pix_clk`, for the panel.

Without bypass, the division ratio is the code plus two. A ratio of one is reached only through the bypass flag, and in that mode the division code is ignored. Software picks the code. The block loads a new setting only when the output period in progress ends, so a change never produces a short pulse.

Top module: `pixclk_divider`

## Requirements
- R1: After reset the configuration word reads zero. The block then divides by 2, is not bypassed and uses the normal edge.
- R2: Configuration word layout: code low part in bits [4:0], code high part in bits [31:27], bypass in bit 26, edge-invert in bit 14. The code is {bits[31:27], bits[4:0]}, a 10-bit value. `bus_rdata` shows the stored word, and all other bits read as zero.
- R3: With bypass clear, `pix_ce` is high for exactly one reference cycle in every period. The period is code + 2 reference cycles.
- R4: With bypass clear, in each period of N cycles `pix_clk` is high for floor(N/2) cycles and low for the rest. For odd N the high time is therefore one cycle shorter than the low time.
- R5: With bypass set, `pix_ce` is high in every cycle and `pix_clk` follows the reference clock, whatever the code holds.
- R6: With edge-invert clear, `pix_ce` is high in the first high cycle of `pix_clk`. With edge-invert set, `pix_ce` is high in the first low cycle of `pix_clk`.
- R7: A new word takes effect only at the end of the period in progress. That period completes with the old ratio.
- R8: The smallest ratio (code 0, divide by 2) and the largest ratio (code 1023, divide by 1025) work like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the configuration word |
| bus_wdata | input | 32 | Configuration word to be written |
| bus_rdata | output | 32 | Stored configuration word, with undefined bits as zero |
| pix_ce | output | 1 | Pixel launch enable, one reference cycle wide |
| pix_clk | output | 1 | Divided pixel clock level |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a long period. The stimulus first locks onto a `pix_ce` pulse of a 20-cycle setting. It then writes a 5-cycle setting a few cycles later and counts cycles until the next pulse and the one after it. Separately, a sweep of every code from 0 to 40 runs. The sweep adds codes that use only the high field and the maximum code, in both edge modes. For each setting, the period, the high time and the edge alignment are computed arithmetically.

// File: rtl/pixclk_div_pkg.sv
package pixclk_div_pkg;

    // Bus word width and field geometry
    localparam int DATA_W  = 32;
    localparam int LO_W    = 5;
    localparam int HI_W    = 5;
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = 27;
    localparam int BYP_POS = 26;
    localparam int INV_POS = 14;

    // Derived widths: code and a counter able to hold code + 2
    localparam int CODE_W = LO_W + HI_W;
    localparam int CNT_W  = CODE_W + 1;

    typedef struct packed {
        logic              bypass;
        logic              invert;
        logic [CODE_W-1:0] code;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{bypass: 1'b0, invert: 1'b0, code: '0};

    // Split the bus word into a configuration; the two code pieces are joined high over low
    function automatic div_cfg_t unpack_word(input logic [DATA_W-1:0] w);
        div_cfg_t c;
        c.code   = {w[HI_LSB +: HI_W], w[LO_LSB +: LO_W]};
        c.bypass = w[BYP_POS];
        c.invert = w[INV_POS];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input div_cfg_t c);
        logic [DATA_W-1:0] w;
        w                  = '0;
        w[LO_LSB +: LO_W]  = c.code[LO_W-1:0];
        w[HI_LSB +: HI_W]  = c.code[CODE_W-1:LO_W];
        w[BYP_POS]         = c.bypass;
        w[INV_POS]         = c.invert;
        return w;
    endfunction

    // Final count value of a period: ratio - 1, zero in bypass
    function automatic logic [CNT_W-1:0] last_count(input div_cfg_t c);
        if (c.bypass)
            return '0;
        return {1'b0, c.code} + CNT_W'(1);
    endfunction

    // Number of high cycles in a period: floor(ratio / 2)
    function automatic logic [CNT_W-1:0] half_len(input div_cfg_t c);
        logic [CNT_W-1:0] n;
        n = {1'b0, c.code} + CNT_W'(2);
        return n >> 1;
    endfunction

endpackage

// File: rtl/pixclk_div_regs.sv
module pixclk_div_regs
    import pixclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output div_cfg_t          cfg
);

    div_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (wr)
            cfg_q <= unpack_word(wdata);
    end

    assign cfg   = cfg_q;
    assign rdata = pack_cfg(cfg_q);

endmodule

// File: rtl/pixclk_div_seq.sv
module pixclk_div_seq
    import pixclk_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  div_cfg_t         pend_cfg,
    output div_cfg_t         act_cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             hi,
    output logic             start,
    output logic             mid
);

    div_cfg_t         act_q, act_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             hi_q, start_q, mid_q;
    logic             hi_nxt, start_nxt, mid_nxt;
    logic             wrap;

    // Period boundary: the pending word is adopted only here
    always_comb begin
        wrap      = (cnt_q == last_count(act_q));
        act_nxt   = wrap ? pend_cfg : act_q;
        cnt_nxt   = wrap ? '0 : cnt_q + CNT_W'(1);
        hi_nxt    = !act_nxt.bypass && (cnt_nxt < half_len(act_nxt));
        start_nxt = (cnt_nxt == '0);
        mid_nxt   = act_nxt.bypass || (cnt_nxt == half_len(act_nxt));
    end

    // Phase flags are registered so the panel clock comes straight from a flop
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= CFG_RESET;
            cnt_q   <= '0;
            hi_q    <= 1'b1;
            start_q <= 1'b1;
            mid_q   <= 1'b0;
        end else begin
            act_q   <= act_nxt;
            cnt_q   <= cnt_nxt;
            hi_q    <= hi_nxt;
            start_q <= start_nxt;
            mid_q   <= mid_nxt;
        end
    end

    assign act_cfg = act_q;
    assign cnt     = cnt_q;
    assign hi      = hi_q;
    assign start   = start_q;
    assign mid     = mid_q;

endmodule

// File: rtl/pixclk_div_out.sv
module pixclk_div_out
    import pixclk_div_pkg::*;
(
    input  logic     clk,
    input  div_cfg_t act_cfg,
    input  logic     hi,
    input  logic     start,
    input  logic     mid,
    output logic     pix_ce,
    output logic     pix_clk
);

    // Launch on the rising phase normally, on the falling phase when inverted
    assign pix_ce  = act_cfg.invert ? mid : start;
    // Bypass hands the reference clock straight through
    assign pix_clk = act_cfg.bypass ? clk : hi;

endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider
    import pixclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pix_ce,
    output logic              pix_clk
);

    div_cfg_t         pend_cfg;
    div_cfg_t         act_cfg;
    logic [CNT_W-1:0] cnt_q;
    logic             hi, start, mid;

    pixclk_div_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (pend_cfg)
    );

    pixclk_div_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .pend_cfg (pend_cfg),
        .act_cfg  (act_cfg),
        .cnt      (cnt_q),
        .hi       (hi),
        .start    (start),
        .mid      (mid)
    );

    pixclk_div_out u_out (
        .clk     (clk),
        .act_cfg (act_cfg),
        .hi      (hi),
        .start   (start),
        .mid     (mid),
        .pix_ce  (pix_ce),
        .pix_clk (pix_clk)
    );

endmodule

// File: rtl/pixclk_divider_chk.sv
module pixclk_divider_chk
    import pixclk_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pix_ce,
    input logic              pix_clk,
    input div_cfg_t          act_cfg,
    input logic [CNT_W-1:0]  cnt_q
);

    localparam logic [DATA_W-1:0] FIELD_MASK =
        pack_cfg('{bypass: 1'b1, invert: 1'b1, code: '1});

    logic at_last;
    assign at_last = (cnt_q == last_count(act_cfg));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && !rst) |-> bus_rdata == ($past(bus_wdata) & FIELD_MASK));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !act_cfg.bypass |-> cnt_q <= ({1'b0, act_cfg.code} + CNT_W'(1)));

    // R5
    bypass_ce_chk: assert property (@(posedge clk) disable iff (rst)
        act_cfg.bypass |-> pix_ce);

    // R6
    rise_align_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_ce && !act_cfg.bypass && !act_cfg.invert) |-> pix_clk);

    // R6
    fall_align_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_ce && !act_cfg.bypass && act_cfg.invert) |-> !pix_clk);

    // R7
    cfg_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(at_last) |-> act_cfg == $past(act_cfg));

endmodule

bind pixclk_divider pixclk_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_ce    (pix_ce),
    .pix_clk   (pix_clk),
    .act_cfg   (act_cfg),
    .cnt_q     (cnt_q)
);

// File: tb/pixclk_divider_bench.sv
module pixclk_divider_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pix_ce;
    logic        pix_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pixclk_divider u_pixclk_divider (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_ce    (pix_ce),
        .pix_clk   (pix_clk)
    );

    // Field positions as stated in R2
    function automatic logic [31:0] enc(input int code, input bit byp, input bit inv);
        logic [31:0] w;
        w = '0;
        w[4:0]   = code[4:0];
        w[31:27] = code[9:5];
        w[26]    = byp;
        w[14]    = inv;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = w;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Step forward until pix_ce is seen at a falling edge
    task automatic wait_ce(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (pix_ce) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // Current sample holds pix_ce; count until the next one
    task automatic period(output int len, output int high, output int end_lvl, output int prev_lvl);
        len  = 1;
        high = int'(pix_clk);
        prev_lvl = int'(pix_clk);
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (pix_ce) break;
            len++;
            high += int'(pix_clk);
            prev_lvl = int'(pix_clk);
        end
        end_lvl = int'(pix_clk);
    endtask

    task automatic run_cfg(input int code, input bit inv);
        int n, len, high, e, p;
        bit ok;
        string rq;
        n  = code + 2;
        rq = (code == 0 || code == 1023) ? "R8" : "R3";
        wr(enc(code, 1'b0, inv));
        wait_ce(ok);
        check(ok, rq, "pix_ce seen", ok, 1);
        period(len, high, e, p);
        period(len, high, e, p);
        check(len == n, rq, $sformatf("period code %0d inv %0d", code, inv), len, n);
        check(high == n / 2, "R4", $sformatf("high time code %0d", code), high, n / 2);
        if (!inv)
            check(e == 1 && p == 0, "R6", "rising alignment", e * 10 + p, 10);
        else
            check(e == 0 && p == 1, "R6", "falling alignment", e * 10 + p, 1);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int len, high, e, p, cnt;
        bit ok;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(bus_rdata == 32'h0, "R1", "reset readback", bus_rdata, 0);
        wait_ce(ok);
        period(len, high, e, p);
        check(len == 2 && high == 1, "R1", "reset period", len, 2);

        // R2 layout: all ones keeps only defined fields
        wr(32'hFFFF_FFFF);
        check(bus_rdata == 32'hFC00_401F, "R2", "mask readback", bus_rdata, 32'hFC00_401F);
        wr(enc(33, 1'b0, 1'b0));
        check(bus_rdata == 32'h0800_0001, "R2", "split code readback", bus_rdata, 32'h0800_0001);

        // R3 R4 R6 sweep of small codes
        for (int c = 0; c <= 40; c++) run_cfg(c, 1'b0);
        run_cfg(511, 1'b0);
        run_cfg(992, 1'b0);
        run_cfg(1023, 1'b0);
        run_cfg(0, 1'b1);
        run_cfg(1, 1'b1);
        run_cfg(2, 1'b1);
        run_cfg(7, 1'b1);
        run_cfg(1023, 1'b1);

        // R5 bypass ignores the code, in both edge modes
        for (int inv = 0; inv < 2; inv++) begin
            wr(enc(37, 1'b1, inv[0]));
            wait_ce(ok);
            wait_ce(ok);
            cnt = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                cnt += int'(pix_ce);
                if (pix_clk) cnt += 100;
            end
            check(cnt == 20, "R5", "bypass ce every cycle, clk low at negedge", cnt, 20);
            @(posedge clk);
            #1;
            check(pix_clk == 1'b1, "R5", "bypass clk high after posedge", pix_clk, 1);
            @(negedge clk);
        end

        // R7 mid-period change
        wr(enc(18, 1'b0, 1'b0));
        wait_ce(ok);
        period(len, high, e, p);
        period(len, high, e, p);
        len = 1;
        repeat (3) begin
            @(negedge clk);
            len++;
        end
        bus_wr    = 1'b1;
        bus_wdata = enc(3, 1'b0, 1'b0);
        @(negedge clk);
        len++;
        bus_wr    = 1'b0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (pix_ce) break;
            len++;
        end
        check(len == 20, "R7", "old period completes", len, 20);
        period(len, high, e, p);
        check(len == 5, "R7", "new period after boundary", len, 5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule